// File: doc/BRIEF.md
# Dual Task Sequencing Controller

This controller decides which of two programmed processing tasks, A or B, owns a video processing pipeline, and when that task may begin. Each task brings its own enable, a two-bit start code, a repeat flag and a field-skip count. The controller watches three inputs from the surrounding logic: vertical sync, the field identifier, and a one-cycle pulse that marks the point where the counted position reaches the programmed window offsets. When a task starts, the controller raises a one-cycle start pulse, holds a running level and inverts a toggle flag. The toggle flag is used further downstream to handle output fields.

A one-cycle end-of-window pulse ends the running task. At that point the controller either reruns the same task, if its repeat flag asks for one more pass, or hands over. Handover goes to the other task when that task is enabled, and otherwise back to the same task. Changes to the enables are sampled only at that handover point, or while the controller is idle. An active-low synchronous software reset sends every internal state straight back to idle.

Top module: `dual_task_sequencer`

## Requirements
- R1: After hardware reset, task_run, task_start and toggle are 0 and task_sel is 0. task_sel uses 0 for task A and 1 for task B.
- R2: While idle, the controller selects task A if en_a is 1, otherwise task B if en_b is 1. With both enables at 0 it stays idle and never starts.
- R3: Start code 2'b00 starts the selected task on the next win_hit pulse.
- R4: Start code 2'b01 starts the task only on a win_hit pulse that comes with or after a vsync pulse seen since the task was selected.
- R5: Start code 2'b10 starts the task only on a win_hit pulse with field_id 0. Start code 2'b11 starts it only on a win_hit pulse with field_id 1.
- R6: With a skip count of N, the first N qualifying trigger events are skipped and the task starts on event N+1. After each skipped event, a start code of 2'b01 needs a new vsync. The count reloads each time the task is selected or repeated.
- R7: On a start, task_start is high for exactly one cycle, toggle inverts, and task_run stays high until win_end. At no other time does toggle change, except on a reset.
- R8: If the repeat flag of the ending task is 1, the same task is armed once more before handover. After that repeat pass, control goes to handover.
- R9: At handover the other task is chosen if it is enabled, otherwise the same task if it is enabled, otherwise the controller goes idle.
- R10: Enable changes made while a task waits or runs have no effect until that task ends.
- R11: When sw_rst_n is sampled low, the next cycle shows the idle state: task_run 0, toggle 0, task_sel 0.
- R12: win_end has no effect when no task is running, and win_hit has no effect while a task is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| sw_rst_n | input | 1 | Synchronous active-low software reset |
| en_a | input | 1 | Task A enable |
| en_b | input | 1 | Task B enable |
| start_a | input | 2 | Task A start code |
| start_b | input | 2 | Task B start code |
| rpt_a | input | 1 | Task A repeat flag |
| rpt_b | input | 1 | Task B repeat flag |
| skip_a | input | SKIP_W | Task A field-skip count |
| skip_b | input | SKIP_W | Task B field-skip count |
| vsync | input | 1 | Vertical sync pulse |
| field_id | input | 1 | Current field identifier |
| win_hit | input | 1 | Pulse when window offsets are reached |
| win_end | input | 1 | Pulse when the running task's window ends |
| task_sel | output | 1 | Selected task, 0 for A and 1 for B |
| task_run | output | 1 | High while the task runs |
| task_start | output | 1 | One-cycle pulse at task activation |
| toggle | output | 1 | Flag inverted on each activation |

## Verification
All outputs come straight from registers. Each output reflects the inputs sampled at one rising edge, and the change is visible right after that same edge, so every result is due one cycle after its stimulus. The bench drives inputs and compares all four outputs one time unit after each rising edge, well before the next edge. It compares them against a cycle model written from the requirements and updated at the same edge. Directed phases for trigger codes, skips, repeats, handover, enable timing and software reset come first. Seeded random traffic follows.

// File: rtl/dts_pkg.sv
package dts_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_RUN  = 2'd2
    } dts_state_e;

    localparam logic [1:0] COND_NOW   = 2'b00;
    localparam logic [1:0] COND_VSYNC = 2'b01;
    localparam logic [1:0] COND_FID0  = 2'b10;
    localparam logic [1:0] COND_FID1  = 2'b11;

    localparam logic SEL_A = 1'b0;
    localparam logic SEL_B = 1'b1;
endpackage

// File: rtl/dts_trigger.sv
module dts_trigger
    import dts_pkg::*;
(
    input  logic [1:0] cond_i,
    input  logic       win_hit_i,
    input  logic       vsync_i,
    input  logic       vs_seen_i,
    input  logic       field_id_i,
    output logic       fire_o
);
    always_comb begin
        unique case (cond_i)
            COND_NOW:   fire_o = win_hit_i;
            COND_VSYNC: fire_o = win_hit_i & (vs_seen_i | vsync_i);
            COND_FID0:  fire_o = win_hit_i & ~field_id_i;
            default:    fire_o = win_hit_i & field_id_i;
        endcase
    end
endmodule

// File: rtl/dts_pick.sv
module dts_pick
    import dts_pkg::*;
(
    input  logic en_a_i,
    input  logic en_b_i,
    input  logic from_run_i,
    input  logic cur_sel_i,
    output logic valid_o,
    output logic sel_o
);
    logic other_en, cur_en;

    always_comb begin
        other_en = (cur_sel_i == SEL_A) ? en_b_i : en_a_i;
        cur_en   = (cur_sel_i == SEL_A) ? en_a_i : en_b_i;
        if (from_run_i) begin
            valid_o = other_en | cur_en;
            sel_o   = other_en ? ~cur_sel_i : cur_sel_i;
        end else begin
            valid_o = en_a_i | en_b_i;
            sel_o   = en_a_i ? SEL_A : SEL_B;
        end
    end
endmodule

// File: rtl/dual_task_sequencer.sv
module dual_task_sequencer
    import dts_pkg::*;
#(
    parameter int SKIP_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_rst_n,
    input  logic              en_a,
    input  logic              en_b,
    input  logic [1:0]        start_a,
    input  logic [1:0]        start_b,
    input  logic              rpt_a,
    input  logic              rpt_b,
    input  logic [SKIP_W-1:0] skip_a,
    input  logic [SKIP_W-1:0] skip_b,
    input  logic              vsync,
    input  logic              field_id,
    input  logic              win_hit,
    input  logic              win_end,
    output logic              task_sel,
    output logic              task_run,
    output logic              task_start,
    output logic              toggle
);
    localparam logic [SKIP_W-1:0] SKIP_ZERO = '0;
    localparam logic [SKIP_W-1:0] SKIP_ONE  = SKIP_W'(1);

    typedef struct packed {
        dts_state_e        state;
        logic              sel;
        logic [SKIP_W-1:0] skip;
        logic              vs_seen;
        logic              rep_done;
        logic              toggle;
        logic              start;
    } seq_t;

    localparam seq_t SEQ_RESET = '{state: ST_IDLE, sel: SEL_A, skip: '0,
                                   vs_seen: 1'b0, rep_done: 1'b0,
                                   toggle: 1'b0, start: 1'b0};

    seq_t seq_d, seq_q;

    logic [1:0]        cur_cond;
    logic              cur_rpt;
    logic [SKIP_W-1:0] cur_skip;
    logic              fire;
    logic              pick_valid, pick_sel;
    logic [SKIP_W-1:0] pick_skip;

    always_comb begin
        cur_cond  = (seq_q.sel == SEL_A) ? start_a : start_b;
        cur_rpt   = (seq_q.sel == SEL_A) ? rpt_a   : rpt_b;
        cur_skip  = (seq_q.sel == SEL_A) ? skip_a  : skip_b;
        pick_skip = (pick_sel  == SEL_A) ? skip_a  : skip_b;
    end

    dts_trigger u_trigger (
        .cond_i     (cur_cond),
        .win_hit_i  (win_hit),
        .vsync_i    (vsync),
        .vs_seen_i  (seq_q.vs_seen),
        .field_id_i (field_id),
        .fire_o     (fire)
    );

    dts_pick u_pick (
        .en_a_i     (en_a),
        .en_b_i     (en_b),
        .from_run_i (seq_q.state == ST_RUN),
        .cur_sel_i  (seq_q.sel),
        .valid_o    (pick_valid),
        .sel_o      (pick_sel)
    );

    always_comb begin
        seq_d       = seq_q;
        seq_d.start = 1'b0;
        unique case (seq_q.state)
            ST_IDLE: begin
                if (pick_valid) begin
                    seq_d.state    = ST_WAIT;
                    seq_d.sel      = pick_sel;
                    seq_d.skip     = pick_skip;
                    seq_d.vs_seen  = 1'b0;
                    seq_d.rep_done = 1'b0;
                end
            end
            ST_WAIT: begin
                if (vsync) seq_d.vs_seen = 1'b1;
                if (fire) begin
                    if (seq_q.skip != SKIP_ZERO) begin
                        seq_d.skip    = seq_q.skip - SKIP_ONE;
                        seq_d.vs_seen = 1'b0;
                    end else begin
                        seq_d.state  = ST_RUN;
                        seq_d.toggle = ~seq_q.toggle;
                        seq_d.start  = 1'b1;
                    end
                end
            end
            ST_RUN: begin
                if (win_end) begin
                    seq_d.vs_seen = 1'b0;
                    if (cur_rpt && !seq_q.rep_done) begin
                        seq_d.state    = ST_WAIT;
                        seq_d.skip     = cur_skip;
                        seq_d.rep_done = 1'b1;
                    end else if (pick_valid) begin
                        seq_d.state    = ST_WAIT;
                        seq_d.sel      = pick_sel;
                        seq_d.skip     = pick_skip;
                        seq_d.rep_done = 1'b0;
                    end else begin
                        seq_d.state = ST_IDLE;
                    end
                end
            end
            default: seq_d = SEQ_RESET;
        endcase
        if (!sw_rst_n) seq_d = SEQ_RESET;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= SEQ_RESET;
        else        seq_q <= seq_d;
    end

    assign task_sel   = seq_q.sel;
    assign task_run   = (seq_q.state == ST_RUN);
    assign task_start = seq_q.start;
    assign toggle     = seq_q.toggle;

    // R7: a start pulse lasts one cycle and coincides with running
    assert_start_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        task_start |-> task_run ##1 !task_start);

    // R7: toggle moves only on a start (or a reset)
    assert_toggle_only_on_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sw_rst_n) && !task_start) |-> $stable(toggle));

    // R7: running holds until the end pulse
    assert_run_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (task_run && !win_end && sw_rst_n) |=> task_run);

    // R11: software reset returns to idle
    assert_swrst_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_rst_n |=> (!task_run && !toggle && !task_sel));

    // R10: selection only moves from idle or at task end
    assert_sel_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_rst_n && seq_q.state == ST_WAIT) |=> $stable(task_sel));
endmodule

// File: tb/tb_dual_task_sequencer.sv
module tb_dual_task_sequencer;
    localparam int CLK_PERIOD = 10;
    localparam int SKIP_W = 3;

    logic clk = 1'b0, rst_n = 1'b0, sw_rst_n = 1'b1;
    logic en_a = 0, en_b = 0, rpt_a = 0, rpt_b = 0;
    logic [1:0] start_a = 0, start_b = 0;
    logic [SKIP_W-1:0] skip_a = 0, skip_b = 0;
    logic vsync = 0, field_id = 0, win_hit = 0, win_end = 0;
    logic task_sel, task_run, task_start, toggle;

    int vectors = 0, fails = 0;
    bit done = 0;
    string phase = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_task_sequencer #(.SKIP_W(SKIP_W)) dut (
        .clk(clk), .rst_n(rst_n), .sw_rst_n(sw_rst_n),
        .en_a(en_a), .en_b(en_b), .start_a(start_a), .start_b(start_b),
        .rpt_a(rpt_a), .rpt_b(rpt_b), .skip_a(skip_a), .skip_b(skip_b),
        .vsync(vsync), .field_id(field_id), .win_hit(win_hit), .win_end(win_end),
        .task_sel(task_sel), .task_run(task_run), .task_start(task_start), .toggle(toggle)
    );

    // reference model: 0 idle, 1 waiting, 2 running
    int m_st = 0;
    logic m_sel = 0, m_seen = 0, m_rep = 0, m_tog = 0, m_start = 0;
    int m_skip = 0;

    function automatic bit f_trig(logic [1:0] c, logic hit, logic vs, logic seen, logic fid);
        if (!hit) return 0;
        case (c)
            2'b00: return 1;
            2'b01: return vs | seen;
            2'b10: return !fid;
            default: return fid;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n || !sw_rst_n) begin
            m_st = 0; m_sel = 0; m_seen = 0; m_rep = 0; m_tog = 0; m_start = 0; m_skip = 0;
        end else begin
            m_start = 0;
            if (m_st == 0) begin
                if (en_a || en_b) begin
                    m_sel = en_a ? 1'b0 : 1'b1;
                    m_skip = m_sel ? skip_b : skip_a;
                    m_st = 1; m_seen = 0; m_rep = 0;
                end
            end else if (m_st == 1) begin
                bit fire;
                fire = f_trig(m_sel ? start_b : start_a, win_hit, vsync, m_seen, field_id);
                if (vsync) m_seen = 1;
                if (fire) begin
                    if (m_skip > 0) begin m_skip--; m_seen = 0; end
                    else begin m_st = 2; m_tog = ~m_tog; m_start = 1; end
                end
            end else if (win_end) begin
                logic oth, cur;
                oth = m_sel ? en_a : en_b;
                cur = m_sel ? en_b : en_a;
                m_seen = 0;
                if ((m_sel ? rpt_b : rpt_a) && !m_rep) begin
                    m_st = 1; m_rep = 1; m_skip = m_sel ? skip_b : skip_a;
                end else if (oth || cur) begin
                    if (oth) m_sel = ~m_sel;
                    m_st = 1; m_rep = 0; m_skip = m_sel ? skip_b : skip_a;
                end else m_st = 0;
            end
        end
    end

    task automatic chk(string tag, logic act, logic exp, string what);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
        chk(phase, task_sel,   m_sel,        "task_sel");
        chk(phase, task_run,   m_st == 2,    "task_run");
        chk(phase, task_start, m_start,      "task_start");
        chk(phase, toggle,     m_tog,        "toggle");
        vsync = 0; win_hit = 0; win_end = 0; sw_rst_n = 1;
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        #(CLK_PERIOD*150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD*2 + 3); rst_n = 1;
        phase = "R1"; tick();
        chk("R1", task_run, 0, "run after reset"); chk("R1", toggle, 0, "toggle after reset");
        chk("R1", task_sel, 0, "sel after reset");
        // R2: nothing enabled stays idle
        phase = "R2"; win_hit = 1; tick(); win_hit = 1; tick(); ticks(2);
        chk("R2", task_run, 0, "idle with no enable");
        en_b = 1; tick(); chk("R2", task_sel, 1, "B chosen when only B enabled");
        // R3: immediate start
        phase = "R3"; start_b = 2'b00; tick(); win_hit = 1; tick();
        chk("R3", task_start, 1, "immediate start pulse"); chk("R3", toggle, 1, "toggle after start");
        // R12: win_hit while running ignored
        phase = "R12"; win_hit = 1; tick(); chk("R12", task_run, 1, "still running");
        chk("R12", task_start, 0, "no restart");
        // R9: only B enabled -> handover to B again
        phase = "R9"; start_b = 2'b01; win_end = 1; tick();
        chk("R9", task_sel, 1, "handover back to B"); chk("R9", task_run, 0, "waiting");
        // R4: vsync needed
        phase = "R4"; win_hit = 1; tick(); chk("R4", task_run, 0, "no start without vsync");
        vsync = 1; tick(); win_hit = 1; tick(); chk("R4", task_start, 1, "start after vsync");
        // R12: win_end when not running ignored after end
        win_end = 1; tick(); phase = "R12"; win_end = 1; tick(); chk("R12", task_run, 0, "end ignored when waiting");
        // R5: field id match
        phase = "R5"; start_b = 2'b10; ticks(1); field_id = 1; win_hit = 1; tick();
        chk("R5", task_run, 0, "fid1 ignored for code 10"); field_id = 0; win_hit = 1; tick();
        chk("R5", task_run, 1, "fid0 starts code 10");
        // R10: enable A mid-run takes effect at end
        phase = "R10"; en_a = 1; start_a = 2'b11; skip_a = 2; tick();
        chk("R10", task_sel, 1, "sel unchanged mid-run"); win_end = 1; tick();
        chk("R10", task_sel, 0, "A taken at end");
        // R6: skip two events
        phase = "R6"; field_id = 1;
        for (int k = 0; k < 2; k++) begin win_hit = 1; tick(); chk("R6", task_run, 0, "skipped event"); end
        win_hit = 1; tick(); chk("R6", task_start, 1, "start after skips");
        // R8: repeat once
        phase = "R8"; rpt_a = 1; skip_a = 0; win_end = 1; tick(); chk("R8", task_sel, 0, "repeat same task");
        win_hit = 1; tick(); win_end = 1; tick(); chk("R8", task_sel, 1, "handover after repeat");
        rpt_a = 0;
        // R11: software reset
        phase = "R11"; start_b = 2'b00; win_hit = 1; tick(); sw_rst_n = 0; tick();
        chk("R11", task_run, 0, "idle after sw reset"); chk("R11", toggle, 0, "toggle cleared");
        // R7: toggle runs over several starts, then random mix
        phase = "R7";
        for (int n = 0; n < 3000; n++) begin
            if ($urandom_range(0, 49) == 0) begin en_a = $urandom; en_b = $urandom; end
            if ($urandom_range(0, 99) == 0) begin
                start_a = $urandom; start_b = $urandom; rpt_a = $urandom; rpt_b = $urandom;
                skip_a = $urandom_range(0, 3); skip_b = $urandom_range(0, 3);
            end
            vsync = ($urandom_range(0, 39) == 0);
            if (vsync) field_id = ~field_id;
            win_hit = ($urandom_range(0, 7) == 0);
            win_end = ($urandom_range(0, 9) == 0);
            sw_rst_n = ($urandom_range(0, 299) != 0);
            @(posedge clk); #1;
            chk("R7", task_sel, m_sel, "rand task_sel");
            chk("R7", task_run, m_st == 2, "rand task_run");
            chk("R7", task_start, m_start, "rand task_start");
            chk("R7", toggle, m_tog, "rand toggle");
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h1234));
    end
endmodule